// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel that sits beside a free-running 16-bit timer. In compare mode it watches the shared count and raises a match when the count becomes equal to its own register. That match, together with a period pulse from the timer's period channel, drives one of eight output waveform modes on a single output pin. In capture mode the channel picks one of four input sources and watches it for the chosen edge. On that edge it copies the timer count into its register.

Both a compare match and a capture set a channel flag. The interrupt request is that flag gated by an enable. When a capture arrives while the flag from an earlier event is still pending, an overflow flag records that a value was lost. Software can read the selected input directly. It can also read a copy of that input latched at the last compare match. The timer counter is not part of this block.

Top module: `ccu_channel`

## Requirements
- R1: `edge_sel_i` chooses the capture trigger: 00 never captures, 01 captures on a rising edge, 10 on a falling edge, 11 on either edge.
- R2: `src_sel_i` chooses the channel input: 00 takes `src_a_i`, 01 takes `src_b_i`, 10 takes constant 0 and 11 takes constant 1. `raw_in_o` shows the chosen input combinationally.
- R3: With `sync_cap_i`=0, an edge on the chosen input that is present at a clock edge loads the count present at that same clock edge. With `sync_cap_i`=1, the capture happens one clock later and loads the count present at that later edge.
- R4: In capture mode (`cap_mode_i`=1), a capture loads `cnt_i` into `ccr_o` and sets `flag_o` at the clock edge of the capture.
- R5: A capture that occurs while `flag_o` is already 1 sets `ovf_o`. `ovf_o` stays set until a clock edge with `ovf_clr_i`=1 and no such capture.
- R6: In compare mode, a match fires only at the first clock edge where `cnt_i` equals `ccr_o` after it was unequal. A count that stays equal does not fire again. A match sets `flag_o` and latches the chosen input into `sync_in_o`.
- R7: With `out_mode_i`=000, `out_o` equals `out_bit_i` combinationally, with no clock in between.
- R8: The single-action modes act on the channel's own match and ignore `period_hit_i`: 001 sets the output, 100 toggles it, 101 clears it.
- R9: In the two-action modes, the first action happens on the own match and the second on `period_hit_i`. The modes are 010 toggle then clear, 011 set then clear, 110 toggle then set, and 111 clear then set. When both occur at the same clock edge, the own-match action wins.
- R10: `irq_o` is `flag_o` AND `irq_en_i`. `flag_clr_i` clears `flag_o` at a clock edge, but a new match or capture at that same edge keeps the flag set.
- R11: `ccr_wr_i` loads `ccr_wdata_i` into `ccr_o`; a capture at the same edge takes priority. In compare mode with no write, `ccr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Shared timer count |
| period_hit_i | input | 1 | One-cycle pulse when the period channel matches |
| src_a_i | input | 1 | Capture source A |
| src_b_i | input | 1 | Capture source B |
| src_sel_i | input | 2 | Input source select |
| edge_sel_i | input | 2 | Capture edge select |
| sync_cap_i | input | 1 | 1 = capture synchronized to the clock |
| cap_mode_i | input | 1 | 0 = compare, 1 = capture |
| out_mode_i | input | 3 | Output waveform mode |
| out_bit_i | input | 1 | Software output value for mode 000 |
| irq_en_i | input | 1 | Interrupt enable |
| ccr_wr_i | input | 1 | Register write strobe |
| ccr_wdata_i | input | 16 | Register write data |
| flag_clr_i | input | 1 | Clear channel flag |
| ovf_clr_i | input | 1 | Clear overflow flag |
| ccr_o | output | 16 | Capture/compare register |
| out_o | output | 1 | Channel output |
| flag_o | output | 1 | Channel event flag |
| ovf_o | output | 1 | Capture overflow flag |
| irq_o | output | 1 | Interrupt request |
| raw_in_o | output | 1 | Chosen input, unregistered |
| sync_in_o | output | 1 | Chosen input latched at the last match |

## Verification
The bench checks each edge code against an edge it should ignore. A channel that decodes rising and falling the wrong way round would capture the wrong count. The bench also compares asynchronous and synchronous capture with counts that change every cycle, so a missing or extra flop stage shows up as an off-by-one captured value. The count is held equal to the register for several cycles with the flag cleared in between, which exposes a level-sensitive match that keeps firing. The bench drives the own match and the period pulse in the same cycle in a two-action mode, so a design that lets the period action win ends with the wrong level. It also raises a clear and a capture together, and raises a capture on a pending flag, to catch a flag that is dropped or an overflow that is never set.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [2:0] {
        OM_BIT     = 3'd0,
        OM_SET     = 3'd1,
        OM_TOG_CLR = 3'd2,
        OM_SET_CLR = 3'd3,
        OM_TOG     = 3'd4,
        OM_CLR     = 3'd5,
        OM_TOG_SET = 3'd6,
        OM_CLR_SET = 3'd7
    } out_mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    typedef enum logic [1:0] {
        SRC_A    = 2'd0,
        SRC_B    = 2'd1,
        SRC_LOW  = 2'd2,
        SRC_HIGH = 2'd3
    } src_sel_e;

    // Next output level for one clock edge; own match beats period hit.
    function automatic logic next_out(input out_mode_e mode, input logic cur,
                                      input logic own, input logic per);
        logic nxt;
        nxt = cur;
        unique case (mode)
            OM_BIT:     nxt = cur;
            OM_SET:     if (own) nxt = 1'b1;
            OM_TOG:     if (own) nxt = ~cur;
            OM_CLR:     if (own) nxt = 1'b0;
            OM_TOG_CLR: if (own) nxt = ~cur; else if (per) nxt = 1'b0;
            OM_SET_CLR: if (own) nxt = 1'b1; else if (per) nxt = 1'b0;
            OM_TOG_SET: if (own) nxt = ~cur; else if (per) nxt = 1'b1;
            OM_CLR_SET: if (own) nxt = 1'b0; else if (per) nxt = 1'b1;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/ccu_insel.sv
module ccu_insel
    import ccu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      src_a_i,
    input  logic      src_b_i,
    input  src_sel_e  src_sel_i,
    input  edge_sel_e edge_sel_i,
    input  logic      sync_cap_i,
    output logic      sel_o,
    output logic      edge_o
);
    logic stg1_q, stg2_q;
    logic cur, prv, rise, fall;

    always_comb begin
        unique case (src_sel_i)
            SRC_A:    sel_o = src_a_i;
            SRC_B:    sel_o = src_b_i;
            SRC_LOW:  sel_o = 1'b0;
            SRC_HIGH: sel_o = 1'b1;
            default:  sel_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg1_q <= 1'b0;
            stg2_q <= 1'b0;
        end else begin
            stg1_q <= sel_o;
            stg2_q <= stg1_q;
        end
    end

    // Synchronous capture looks one stage further down the pipe.
    assign cur  = sync_cap_i ? stg1_q : sel_o;
    assign prv  = sync_cap_i ? stg2_q : stg1_q;
    assign rise = cur & ~prv;
    assign fall = ~cur & prv;

    always_comb begin
        unique case (edge_sel_i)
            EDGE_NONE: edge_o = 1'b0;
            EDGE_RISE: edge_o = rise;
            EDGE_FALL: edge_o = fall;
            EDGE_BOTH: edge_o = rise | fall;
            default:   edge_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ccu_capcmp.sv
module ccu_capcmp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt_i,
    input  logic         cap_mode_i,
    input  logic         cap_edge_i,
    input  logic         sel_i,
    input  logic         ccr_wr_i,
    input  logic [W-1:0] ccr_wdata_i,
    input  logic         flag_clr_i,
    input  logic         ovf_clr_i,
    output logic [W-1:0] ccr_o,
    output logic         match_o,
    output logic         flag_o,
    output logic         ovf_o,
    output logic         sync_in_o
);
    logic eq, eq_q, cap_ev;

    assign eq      = (cnt_i == ccr_o);
    assign match_o = eq & ~eq_q & ~cap_mode_i;
    assign cap_ev  = cap_mode_i & cap_edge_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_o     <= '0;
            eq_q      <= 1'b0;
            flag_o    <= 1'b0;
            ovf_o     <= 1'b0;
            sync_in_o <= 1'b0;
        end else begin
            eq_q <= eq;
            if (cap_ev)        ccr_o <= cnt_i;
            else if (ccr_wr_i) ccr_o <= ccr_wdata_i;

            if (cap_ev || match_o) flag_o <= 1'b1;
            else if (flag_clr_i)   flag_o <= 1'b0;

            if (cap_ev && flag_o)  ovf_o <= 1'b1;
            else if (ovf_clr_i)    ovf_o <= 1'b0;

            if (match_o) sync_in_o <= sel_i;
        end
    end
endmodule

// File: rtl/ccu_outunit.sv
module ccu_outunit
    import ccu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  out_mode_e mode_i,
    input  logic      out_bit_i,
    input  logic      match_i,
    input  logic      period_i,
    output logic      out_o
);
    logic out_q;

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= 1'b0;
        else if (mode_i == OM_BIT)
            out_q <= out_bit_i;
        else
            out_q <= next_out(mode_i, out_q, match_i, period_i);
    end

    assign out_o = (mode_i == OM_BIT) ? out_bit_i : out_q;
endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
    import ccu_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt_i,
    input  logic         period_hit_i,
    input  logic         src_a_i,
    input  logic         src_b_i,
    input  logic [1:0]   src_sel_i,
    input  logic [1:0]   edge_sel_i,
    input  logic         sync_cap_i,
    input  logic         cap_mode_i,
    input  logic [2:0]   out_mode_i,
    input  logic         out_bit_i,
    input  logic         irq_en_i,
    input  logic         ccr_wr_i,
    input  logic [W-1:0] ccr_wdata_i,
    input  logic         flag_clr_i,
    input  logic         ovf_clr_i,
    output logic [W-1:0] ccr_o,
    output logic         out_o,
    output logic         flag_o,
    output logic         ovf_o,
    output logic         irq_o,
    output logic         raw_in_o,
    output logic         sync_in_o
);
    logic sel, cap_edge, match;

    ccu_insel u_insel (
        .clk        (clk),
        .rst        (rst),
        .src_a_i    (src_a_i),
        .src_b_i    (src_b_i),
        .src_sel_i  (src_sel_e'(src_sel_i)),
        .edge_sel_i (edge_sel_e'(edge_sel_i)),
        .sync_cap_i (sync_cap_i),
        .sel_o      (sel),
        .edge_o     (cap_edge)
    );

    ccu_capcmp #(.W(W)) u_capcmp (
        .clk         (clk),
        .rst         (rst),
        .cnt_i       (cnt_i),
        .cap_mode_i  (cap_mode_i),
        .cap_edge_i  (cap_edge),
        .sel_i       (sel),
        .ccr_wr_i    (ccr_wr_i),
        .ccr_wdata_i (ccr_wdata_i),
        .flag_clr_i  (flag_clr_i),
        .ovf_clr_i   (ovf_clr_i),
        .ccr_o       (ccr_o),
        .match_o     (match),
        .flag_o      (flag_o),
        .ovf_o       (ovf_o),
        .sync_in_o   (sync_in_o)
    );

    ccu_outunit u_out (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (out_mode_e'(out_mode_i)),
        .out_bit_i (out_bit_i),
        .match_i   (match),
        .period_i  (period_hit_i),
        .out_o     (out_o)
    );

    assign raw_in_o = sel;
    assign irq_o    = flag_o & irq_en_i;
endmodule

// File: rtl/ccu_channel_chk.sv
module ccu_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cap_mode_i,
    input logic [1:0]   edge_sel_i,
    input logic         ccr_wr_i,
    input logic [2:0]   out_mode_i,
    input logic [W-1:0] ccr_o,
    input logic         out_o,
    input logic         flag_o,
    input logic         ovf_o
);
    AST_NO_CAPTURE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (cap_mode_i && edge_sel_i == 2'b00 && !ccr_wr_i) |=> $stable(ccr_o)); // R1

    AST_OVF_AFTER_PENDING: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> $past(flag_o)); // R5

    AST_OVF_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> flag_o); // R5

    AST_SET_MODE_STICKS: assert property (@(posedge clk) disable iff (rst)
        (out_mode_i == 3'd1 && out_o) |=> (out_mode_i != 3'd1 || out_o)); // R8

    AST_CLR_MODE_STICKS: assert property (@(posedge clk) disable iff (rst)
        (out_mode_i == 3'd5 && !out_o) |=> (out_mode_i != 3'd5 || !out_o)); // R8

    AST_CCR_HOLDS_IN_COMPARE: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode_i && !ccr_wr_i) |=> $stable(ccr_o)); // R11
endmodule

bind ccu_channel ccu_channel_chk #(.W(W)) u_chk (.*);

// File: tb/tb_ccu_channel.sv
module tb_ccu_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cnt_i;
    logic        period_hit_i, src_a_i, src_b_i;
    logic [1:0]  src_sel_i, edge_sel_i;
    logic        sync_cap_i, cap_mode_i;
    logic [2:0]  out_mode_i;
    logic        out_bit_i, irq_en_i, ccr_wr_i;
    logic [15:0] ccr_wdata_i;
    logic        flag_clr_i, ovf_clr_i;
    logic [15:0] ccr_o;
    logic        out_o, flag_o, ovf_o, irq_o, raw_in_o, sync_in_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccu_channel dut (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_flags();
        flag_clr_i = 1'b1; ovf_clr_i = 1'b1;
        step();
        flag_clr_i = 1'b0; ovf_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; cnt_i = 16'd100; period_hit_i = 0; src_a_i = 0; src_b_i = 0;
        src_sel_i = 0; edge_sel_i = 0; sync_cap_i = 0; cap_mode_i = 0;
        out_mode_i = 0; out_bit_i = 0; irq_en_i = 0; ccr_wr_i = 0;
        ccr_wdata_i = 0; flag_clr_i = 0; ovf_clr_i = 0;
        repeat (3) step();
        rst = 1'b0;
        chk("reset ccr", ccr_o, 16'd0);
        chk("reset out", out_o, 0);
        chk("reset flag", flag_o, 0);
        chk("reset ovf", ovf_o, 0);
        chk("reset irq", irq_o, 0);
        chk("reset sync_in", sync_in_o, 0);
    endtask

    task automatic t_insel();
        src_a_i = 1; src_b_i = 0;
        for (int s = 0; s < 4; s++) begin
            src_sel_i = s[1:0]; #1;
            chk("R2 raw A=1", raw_in_o, (s == 0 || s == 3) ? 16'd1 : 16'd0);
        end
        src_a_i = 0; src_b_i = 1;
        for (int s = 0; s < 4; s++) begin
            src_sel_i = s[1:0]; #1;
            chk("R2 raw B=1", raw_in_o, (s == 1 || s == 3) ? 16'd1 : 16'd0);
        end
        src_sel_i = 0; src_a_i = 0; src_b_i = 0;
        step(); step();
    endtask

    task automatic t_capture_edges();
        cap_mode_i = 1; sync_cap_i = 0; edge_sel_i = 2'b01;
        cnt_i = 200; src_a_i = 1; step();
        chk("R4 R1 rise capture", ccr_o, 16'd200);
        chk("R4 flag on capture", flag_o, 1);
        cnt_i = 210; src_a_i = 0; step();
        chk("R1 rise ignores fall", ccr_o, 16'd200);
        clear_flags();
        edge_sel_i = 2'b10;
        cnt_i = 220; src_a_i = 1; step();
        chk("R1 fall ignores rise", ccr_o, 16'd200);
        cnt_i = 230; src_a_i = 0; step();
        chk("R1 fall capture", ccr_o, 16'd230);
        edge_sel_i = 2'b11;
        cnt_i = 240; src_a_i = 1; step();
        chk("R1 both rise", ccr_o, 16'd240);
        cnt_i = 250; src_a_i = 0; step();
        chk("R1 both fall", ccr_o, 16'd250);
        edge_sel_i = 2'b00;
        cnt_i = 260; src_a_i = 1; step();
        src_a_i = 0; step();
        chk("R1 none never captures", ccr_o, 16'd250);
    endtask

    task automatic t_sync();
        clear_flags();
        edge_sel_i = 2'b01; sync_cap_i = 1; src_a_i = 0;
        step(); step();
        cnt_i = 300; src_a_i = 1; step();
        chk("R3 sync no capture yet", ccr_o, 16'd250);
        cnt_i = 301; step();
        chk("R3 sync capture one later", ccr_o, 16'd301);
        sync_cap_i = 0; src_a_i = 0; step(); step();
    endtask

    task automatic t_overflow();
        clear_flags();
        cnt_i = 400; src_a_i = 1; step();
        chk("R5 first capture no ovf", ovf_o, 0);
        src_a_i = 0; step();
        cnt_i = 410; src_a_i = 1; step();
        chk("R5 ovf on pending flag", ovf_o, 1);
        chk("R4 second capture value", ccr_o, 16'd410);
        ovf_clr_i = 1; step(); ovf_clr_i = 0;
        chk("R5 ovf cleared", ovf_o, 0);
        chk("R5 flag kept", flag_o, 1);
    endtask

    task automatic t_irq();
        irq_en_i = 0; #1;
        chk("R10 irq masked", irq_o, 0);
        irq_en_i = 1; #1;
        chk("R10 irq enabled", irq_o, 1);
        src_a_i = 0; step();
        cnt_i = 420; src_a_i = 1; flag_clr_i = 1; step();
        chk("R10 set beats clear", flag_o, 1);
        step(); flag_clr_i = 0;
        chk("R10 flag cleared", flag_o, 0);
        chk("R10 irq drops", irq_o, 0);
        irq_en_i = 0; src_a_i = 0; step();
        clear_flags();
    endtask

    task automatic t_compare();
        cnt_i = 600; src_a_i = 1; ccr_wr_i = 1; ccr_wdata_i = 16'd777; step();
        chk("R11 capture beats write", ccr_o, 16'd600);
        ccr_wr_i = 0; src_a_i = 0; cap_mode_i = 0; step();
        clear_flags();
        cnt_i = 100; ccr_wr_i = 1; ccr_wdata_i = 16'd500; step(); ccr_wr_i = 0;
        chk("R11 write loads", ccr_o, 16'd500);
        out_mode_i = 0; out_bit_i = 1; #1;
        chk("R7 bit high", out_o, 1);
        out_bit_i = 0; #1;
        chk("R7 bit low", out_o, 0);
        src_sel_i = 2'd3; cnt_i = 500; step();
        chk("R6 match sets flag", flag_o, 1);
        chk("R6 sync_in latched high", sync_in_o, 1);
        flag_clr_i = 1; step(); flag_clr_i = 0; step();
        chk("R6 held equality no refire", flag_o, 0);
        cnt_i = 501; step();
        src_sel_i = 2'd2; cnt_i = 500; step();
        chk("R6 refire after unequal", flag_o, 1);
        chk("R6 sync_in latched low", sync_in_o, 0);
        cnt_i = 501; step();
        clear_flags();
    endtask

    task automatic own_match();
        cnt_i = 500; step();
        cnt_i = 501; step();
    endtask

    task automatic per_hit();
        period_hit_i = 1; step(); period_hit_i = 0;
    endtask

    task automatic t_outmodes();
        out_mode_i = 3'd0; out_bit_i = 0; step();
        out_mode_i = 3'd1; own_match();
        chk("R8 set on match", out_o, 1);
        per_hit();
        chk("R8 set ignores period", out_o, 1);
        out_mode_i = 3'd4; own_match();
        chk("R8 toggle 1", out_o, 0);
        own_match();
        chk("R8 toggle 2", out_o, 1);
        per_hit();
        chk("R8 toggle ignores period", out_o, 1);
        out_mode_i = 3'd5; own_match();
        chk("R8 clear on match", out_o, 0);
        out_mode_i = 3'd2; own_match();
        chk("R9 tog/clr match", out_o, 1);
        per_hit();
        chk("R9 tog/clr period", out_o, 0);
        out_mode_i = 3'd3; own_match();
        chk("R9 set/clr match", out_o, 1);
        per_hit();
        chk("R9 set/clr period", out_o, 0);
        out_mode_i = 3'd6; own_match();
        chk("R9 tog/set match", out_o, 1);
        own_match();
        chk("R9 tog/set match again", out_o, 0);
        per_hit();
        chk("R9 tog/set period", out_o, 1);
        out_mode_i = 3'd7; own_match();
        chk("R9 clr/set match", out_o, 0);
        per_hit();
        chk("R9 clr/set period", out_o, 1);
        out_mode_i = 3'd3; per_hit();
        chk("R9 set/clr period first", out_o, 0);
        cnt_i = 500; period_hit_i = 1; step();
        period_hit_i = 0; cnt_i = 501;
        chk("R9 own match wins", out_o, 1);
        step();
        out_mode_i = 3'd0; out_bit_i = 0; #1;
        chk("R7 back to bit", out_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_insel();
        t_capture_edges();
        t_sync();
        t_overflow();
        t_irq();
        t_compare();
        t_outmodes();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule